// File: doc/BRIEF.md
# Graphics Command Queue with Host Stall

This block sits between the host register-write path and a graphics drawing engine. The host writes a series of parameter words, such as drawing direction, colours or the major axis of a line, and then one function command word. Each write carries a 6-bit register index and a 32-bit data word. The block holds up to eight such entries in arrival order. Writes complete with no wait state while there is space. When the queue is full, the block raises a wait request that holds the host bus until a slot frees up.

On the engine side, entries leave the queue in order. A parameter entry is copied into a bank of shadow registers that the engine reads. A command entry is presented to the engine with a one-cycle start pulse. The queue then sets busy and stops draining until the engine reports done. The next batch of parameters can therefore wait in the queue without disturbing the operation that is running. Full, empty, busy and fill-level outputs let software check for free space before it writes.

The host input is a valid/ready stream. A write is taken on a rising clock edge where `wr_valid` and `wr_ready` are both high. When `wr_ready` is low, the host must hold `wr_valid`, `wr_idx` and `wr_data` stable, and `wait_req` tells the bus sequencer to stretch the cycle. A held write is taken in the same cycle that an entry leaves a full queue. The engine side uses a plain start/done pair.

Top module: `gfx_cmd_queue`

## Requirements
- R1: After reset `st_empty`=1, `st_full`=0, `st_busy`=0, `st_level`=0, `wr_ready`=1, `eng_start`=0 and every shadow register reads 0.
- R2: While fewer than 8 entries are held, `wr_ready` is 1 and a write with `wr_valid`=1 is taken at the next rising edge with no wait state.
- R3: With 8 entries held and no entry leaving, `st_full`=1, `wr_ready`=0 and `wait_req` equals `wr_valid`; the level never goes above 8.
- R4: A write held against a full queue is taken in the same cycle that an entry leaves, so the level stays at 8.
- R5: Entries leave in the order they were written; a later write to the same index overrides an earlier one.
- R6: An entry with an index below 16 is a parameter. When it is at the head and the engine is idle, it is copied at the next edge into shadow slot `idx`, which is `params[idx*32 +: 32]`.
- R7: An entry with an index of 16 or more is a command. Leaving the queue, it drives `eng_start` high for exactly one cycle, loads `eng_code` with the index and `eng_arg` with the data, and sets `st_busy`.
- R8: While `st_busy` is 1, no entry leaves the queue and the shadow registers keep their values.
- R9: `eng_done` while busy clears `st_busy` at the next edge. `eng_done` while idle has no effect.
- R10: `st_empty` is 1 exactly when `st_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Queue can take the write this cycle |
| wr_idx | input | 6 | Register index of the write |
| wr_data | input | 32 | Data of the write |
| wait_req | output | 1 | Stall request to the bus sequencer |
| eng_done | input | 1 | Engine finished the current operation |
| eng_start | output | 1 | One-cycle start pulse for a command |
| eng_code | output | 6 | Index of the last command |
| eng_arg | output | 32 | Data of the last command |
| params | output | 512 | Sixteen 32-bit shadow parameter registers |
| st_full | output | 1 | Queue holds 8 entries |
| st_empty | output | 1 | Queue holds no entry |
| st_busy | output | 1 | Engine operation in progress |
| st_level | output | 4 | Number of entries held |

## Verification
Single writes that the engine drains at once are tried with parameters at the lowest, a middle and the highest parameter index, and with commands at the lowest and highest command index. This tells the parameter/command split apart at the threshold and checks the shadow slot selection. A batch written while an operation runs fills the queue, so the stall, the held write taken on the freeing pop, and the halt of draining while busy can each be seen. The batch writes index 0 on both sides of a command, which shows that order is kept and that busy holds the later value back. A done pulse with no operation running shows that done is ignored when idle.

// File: rtl/gfx_cmd_queue_pkg.sv
package gfx_cmd_queue_pkg;
  localparam int unsigned DEF_DEPTH    = 8;
  localparam int unsigned DEF_IDX_W    = 6;
  localparam int unsigned DEF_DATA_W   = 32;
  localparam int unsigned DEF_CMD_BASE = 16;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_RUN  = 1'b1
  } eng_state_e;
endpackage

// File: rtl/gcq_fifo.sv
module gcq_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 38,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty,
  output logic [LVL_W-1:0] level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full  = (level == LVL_W'(DEPTH));
  assign empty = (level == '0);
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      case ({push, pop})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |-> pop);
  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_push_counts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> level == $past(level) + LVL_W'(1));
endmodule

// File: rtl/gcq_shadow_bank.sv
module gcq_shadow_bank #(
  parameter int unsigned SLOTS  = 16,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        widx,
  input  logic [DATA_W-1:0]       wdata,
  output logic [SLOTS*DATA_W-1:0] q
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [DATA_W-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            r <= '0;
      else if (we && widx == IDX_W'(i))      r <= wdata;
    end
    assign q[i*DATA_W +: DATA_W] = r;
  end

  assert_param_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> widx < IDX_W'(SLOTS));
endmodule

// File: rtl/gcq_dispatch.sv
module gcq_dispatch
  import gfx_cmd_queue_pkg::*;
#(
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CMD_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_valid,
  input  logic [IDX_W-1:0]  head_idx,
  input  logic [DATA_W-1:0] head_data,
  input  logic              done,
  output logic              pop,
  output logic              param_we,
  output logic              start,
  output logic              busy,
  output logic [IDX_W-1:0]  code,
  output logic [DATA_W-1:0] arg
);
  eng_state_e st;
  logic head_is_cmd;

  assign busy        = (st == ENG_RUN);
  assign head_is_cmd = (head_idx >= IDX_W'(CMD_BASE));
  assign pop         = head_valid && !busy;
  assign param_we    = pop && !head_is_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ENG_IDLE;
      start <= 1'b0;
      code  <= '0;
      arg   <= '0;
    end else begin
      start <= 1'b0;
      case (st)
        ENG_IDLE: if (pop && head_is_cmd) begin
          st    <= ENG_RUN;
          start <= 1'b1;
          code  <= head_idx;
          arg   <= head_data;
        end
        ENG_RUN: if (done) st <= ENG_IDLE;
        default: st <= ENG_IDLE;
      endcase
    end
  end

  assert_start_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
  assert_start_sets_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> busy);
  assert_no_pop_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pop);
  assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done) |=> !busy);
  assert_idle_done_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !pop) |=> !busy && !start);
endmodule

// File: rtl/gfx_cmd_queue.sv
module gfx_cmd_queue
  import gfx_cmd_queue_pkg::*;
#(
  parameter int unsigned DEPTH    = DEF_DEPTH,
  parameter int unsigned IDX_W    = DEF_IDX_W,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned CMD_BASE = DEF_CMD_BASE,
  localparam int unsigned ENT_W   = IDX_W + DATA_W,
  localparam int unsigned LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  output logic                       wr_ready,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [DATA_W-1:0]          wr_data,
  output logic                       wait_req,
  input  logic                       eng_done,
  output logic                       eng_start,
  output logic [IDX_W-1:0]           eng_code,
  output logic [DATA_W-1:0]          eng_arg,
  output logic [CMD_BASE*DATA_W-1:0] params,
  output logic                       st_full,
  output logic                       st_empty,
  output logic                       st_busy,
  output logic [LVL_W-1:0]           st_level
);
  logic             push, pop, param_we;
  logic [ENT_W-1:0] head;

  assign wr_ready = !st_full || pop;
  assign push     = wr_valid && wr_ready;
  assign wait_req = wr_valid && !wr_ready;

  gcq_fifo #(.DEPTH(DEPTH), .WIDTH(ENT_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   ({wr_idx, wr_data}),
    .pop   (pop),
    .dout  (head),
    .full  (st_full),
    .empty (st_empty),
    .level (st_level)
  );

  gcq_dispatch #(.IDX_W(IDX_W), .DATA_W(DATA_W), .CMD_BASE(CMD_BASE)) u_disp (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_valid (!st_empty),
    .head_idx   (head[ENT_W-1 -: IDX_W]),
    .head_data  (head[DATA_W-1:0]),
    .done       (eng_done),
    .pop        (pop),
    .param_we   (param_we),
    .start      (eng_start),
    .busy       (st_busy),
    .code       (eng_code),
    .arg        (eng_arg)
  );

  gcq_shadow_bank #(.SLOTS(CMD_BASE), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_shadow (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (param_we),
    .widx  (head[ENT_W-1 -: IDX_W]),
    .wdata (head[DATA_W-1:0]),
    .q     (params)
  );

  assert_wait_only_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wait_req |-> (st_full && wr_valid));
  assert_held_write_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && st_full && pop) |=> st_level == LVL_W'(DEPTH));
  assert_shadow_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_busy |=> $stable(params));
  assert_empty_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st_empty == (st_level == '0));
endmodule

// File: tb/tb_gfx_cmd_queue.sv
module tb_gfx_cmd_queue;
  localparam int DW = 32;
  localparam int IW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, eng_done = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, wait_req, eng_start, st_full, st_empty, st_busy;
  logic [IW-1:0] eng_code;
  logic [DW-1:0] eng_arg;
  logic [16*DW-1:0] params;
  logic [3:0] st_level;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  gfx_cmd_queue dut (.*);

  // vector: {is_cmd, idx, data}
  localparam int NV = 6;
  localparam logic [IW+DW:0] VEC [NV] = '{
    {1'b0, 6'd0,  32'hA5A5_0001},
    {1'b0, 6'd15, 32'hDEAD_BEEF},
    {1'b1, 6'd16, 32'h0000_1234},
    {1'b0, 6'd5,  32'h5555_AAAA},
    {1'b1, 6'd63, 32'hFFFF_0000},
    {1'b0, 6'd15, 32'h0BAD_F00D}
  };

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] slot(int i);
    return params[i*DW +: DW];
  endfunction

  task automatic push1(logic [IW-1:0] i, logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pulse_done;
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d expected <20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 empty", st_empty, 1);
    check("R1 full", st_full, 0);
    check("R1 busy", st_busy, 0);
    check("R1 level", st_level, 0);
    check("R1 ready", wr_ready, 1);
    check("R1 start", eng_start, 0);
    check("R1 params", (params == '0), 1);
    check("R10 empty at level 0", st_empty, st_level == 0);

    // table walk: R2, R6, R7, R9
    for (int v = 0; v < NV; v++) begin
      logic c; logic [IW-1:0] i; logic [DW-1:0] d;
      {c, i, d} = VEC[v];
      check("R2 ready before write", wr_ready, 1);
      push1(i, d);
      @(negedge clk);
      if (!c) begin
        check("R6 shadow slot", slot(i), d);
        check("R6 no busy", st_busy, 0);
      end else begin
        check("R7 start pulse", eng_start, 1);
        check("R7 code", eng_code, i);
        check("R7 arg", eng_arg, d);
        check("R7 busy", st_busy, 1);
        @(negedge clk);
        check("R7 start one cycle", eng_start, 0);
        pulse_done();
        check("R9 done clears busy", st_busy, 0);
      end
    end
    check("R5 later write wins", slot(15), 32'h0BAD_F00D);
    check("R10 empty after drain", st_empty, 1);

    // R9 done while idle is ignored
    pulse_done();
    check("R9 idle done busy", st_busy, 0);
    check("R9 idle done start", eng_start, 0);
    check("R9 idle done level", st_level, 0);

    // start a long operation
    push1(6'd20, 32'hC0C0_0000);
    @(negedge clk);
    check("R7 busy for batch", st_busy, 1);
    // fill the queue: params 0..6 then command 20
    for (int k = 0; k < 8; k++) begin
      check("R2 ready while space", wr_ready, 1);
      wr_valid = 1'b1;
      wr_idx   = (k < 7) ? IW'(k) : 6'd20;
      wr_data  = (k < 7) ? 32'h1000_0000 + DW'(k) : 32'hC0C0_0001;
      @(negedge clk);
    end
    // ninth write held
    wr_idx = 6'd0; wr_data = 32'hB0B0_0000;
    #1;
    check("R3 full", st_full, 1);
    check("R3 ready low", wr_ready, 0);
    check("R3 wait_req", wait_req, 1);
    check("R10 not empty", st_empty, 0);
    repeat (3) @(negedge clk);
    check("R3 level capped", st_level, 8);
    check("R8 shadow held", slot(0), 32'hA5A5_0001);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
    #1;
    check("R4 ready on pop", wr_ready, 1);
    check("R4 wait dropped", wait_req, 0);
    @(negedge clk);
    wr_valid = 1'b0;
    check("R4 level stays 8", st_level, 8);
    check("R5 first param applied", slot(0), 32'h1000_0000);
    repeat (10) @(negedge clk);
    check("R8 busy after second cmd", st_busy, 1);
    check("R8 one entry left", st_level, 1);
    check("R8 later idx0 held back", slot(0), 32'h1000_0000);
    check("R5 param 6 in order", slot(6), 32'h1000_0006);
    check("R7 second code", eng_arg, 32'hC0C0_0001);
    pulse_done();
    @(negedge clk);
    check("R5 idx0 after command", slot(0), 32'hB0B0_0000);
    check("R10 drained", st_empty, 1);
    finish_run();
  end
endmodule